// File: doc/BRIEF.md
# Inner Label Type Classifier

This block watches the bytes of an encapsulated data frame as they arrive, one byte per accepted cycle, and decides how the inner frame is labeled. The two-byte type field that follows the inner destination and source MAC addresses selects one of three outcomes. A value of 0x8100 means a single 12-bit VLAN tag word follows. A value of 0x893B means a 24-bit fine label follows, split over two tag words. Any other value means the frame is of an unknown kind. The classifier extracts the label, the priority and drop-eligibility bits used for forwarding, and a flow key for equal-cost path selection. It raises a drop flag for frames that must not be forwarded.

The encapsulation header ahead of the inner MAC addresses has a fixed length, set by the parameter `INNER_OFS`. Bytes are numbered from 0 at the byte that carries `in_sof`. The result comes out as a one-cycle pulse on `res_valid`, with registered fields, as soon as the last byte needed for the decision has been taken. A frame that ends before the decision can be made produces a one-cycle `res_trunc` pulse and no result. After the decision, the classifier ignores the rest of the frame.

Top module: `inner_label_classifier`

## Requirements
- R1: If bytes OFS+12 and OFS+13 (big-endian, OFS = INNER_OFS) read 0x8100, the tag word at OFS+14..OFS+15 gives the result. The type is 1, the label is {12'h000, word[11:0]}, the priority is word[15:13], the DEI bit is word[12] and drop is 0. `res_valid` is high in the cycle after byte OFS+15 is taken.
- R2: If the type field reads 0x893B and VLAN-only mode is off, the frame is fine-labeled. The high word sits at OFS+14..15, the second type field at OFS+16..17 and the low word at OFS+18..19. The type is 2, the label is {high[11:0], low[11:0]}, the priority and DEI come from high[15:12], and drop is 0. `res_valid` is high in the cycle after byte OFS+19.
- R3: Any other value in the type field gives type 3, drop 1, label 0, priority 0, DEI 0 and flow key 0. The result comes in the cycle after byte OFS+13, and no later byte of that frame yields a result.
- R4: If the second type field of a fine-labeled frame is not 0x893B, the result is type 3 with drop 1, label 0 and flow key 0, in the cycle after byte OFS+17.
- R5: With `vlan_only` high at byte OFS+13, a 0x893B type field gives type 0 (malformed) with drop 1, label 0 and flow key 0, in the cycle after byte OFS+13.
- R6: If `in_eof` comes with a taken byte before the deciding byte, `res_trunc` pulses for one cycle in the following cycle and `res_valid` stays low for that frame. An end marker on the deciding byte itself gives a normal result.
- R7: For types 1 and 2 the flow key is {label[23:0], fold}, where fold is the XOR of the 12 inner MAC bytes OFS..OFS+11. Fine labels that differ in either 12-bit part therefore give different keys.
- R8: `res_valid` is never high for two cycles in a row, and each frame gives at most one result or truncation pulse. Cycles with `in_valid` low do not advance the byte count. Bytes that arrive outside a frame are ignored.
- R9: After reset, `res_valid`, `res_trunc`, `res_type`, `res_label`, `res_prio`, `res_dei`, `res_drop` and `res_flow_key` are all zero.
- R10: `vlan_only` has no effect on 0x8100 frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A frame byte is present |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| vlan_only | input | 1 | Reject fine-labeled frames as malformed |
| res_valid | output | 1 | One-cycle result strobe |
| res_type | output | 2 | 0 malformed, 1 VLAN, 2 fine, 3 unknown |
| res_label | output | 24 | Extracted label, 0 when dropped |
| res_prio | output | 3 | Forwarding priority |
| res_dei | output | 1 | Forwarding drop-eligibility bit |
| res_drop | output | 1 | Frame must be discarded |
| res_trunc | output | 1 | One-cycle truncation strobe |
| res_flow_key | output | 32 | Path-selection flow key |

## Verification
Errors in the byte position show up straight away at the ports. If the counter is off by one, the deciding byte moves, so the strobe lands a cycle early or late. Such an error also shifts the label bits, which the checks catch on the first frame. A frame-tracking flag that stays set too long shows up as a second strobe from the tail of an unknown-type frame. One that is cleared too early shows up as a truncation pulse that never comes. A fold register that is not cleared at the start of a frame corrupts the flow key of the next frame. So each test sends frames back to back.

// File: rtl/ilc_pkg.sv
package ilc_pkg;

  typedef enum logic [1:0] {
    LT_REJECT  = 2'd0,
    LT_VLAN    = 2'd1,
    LT_FINE    = 2'd2,
    LT_UNKNOWN = 2'd3
  } lbl_type_e;

  localparam logic [15:0] ET_VLAN_TAG  = 16'h8100;
  localparam logic [15:0] ET_FINE_TAG  = 16'h893B;
  localparam int          LBL_W        = 24;
  localparam int          KEY_W        = 32;

  // accumulate one inner MAC byte into the flow fold
  function automatic logic [7:0] fold_step(input logic [7:0] acc,
                                           input logic [7:0] b);
    return acc ^ b;
  endfunction

  // full label in the upper bits so no two labels share a key
  function automatic logic [KEY_W-1:0] make_flow_key(input logic [LBL_W-1:0] lbl,
                                                     input logic [7:0] fold);
    return {lbl, fold};
  endfunction

  function automatic logic [LBL_W-1:0] fine_label(input logic [15:0] hi_w,
                                                  input logic [15:0] lo_w);
    return {hi_w[11:0], lo_w[11:0]};
  endfunction

endpackage

// File: rtl/ilc_pos_tracker.sv
module ilc_pos_tracker #(
  parameter int LIMIT = 24,
  parameter int POS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             stop,
  output logic             take,
  output logic [POS_W-1:0] idx
);

  localparam logic [POS_W-1:0] POS_MAX = POS_W'(LIMIT);

  logic             in_frame_q;
  logic [POS_W-1:0] pos_q;

  assign take = in_valid && (in_sof || in_frame_q);
  assign idx  = in_sof ? '0 : pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      pos_q      <= '0;
    end else if (take) begin
      in_frame_q <= !(in_eof || stop);
      pos_q      <= (idx == POS_MAX) ? idx : idx + 1'b1;
    end
  end

  // R8
  stop_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> take);

  // R8
  pos_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_MAX);

endmodule

// File: rtl/ilc_mac_fold.sv
module ilc_mac_fold #(
  parameter int OFS   = 4,
  parameter int POS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             in_sof,
  input  logic [POS_W-1:0] idx,
  input  logic [7:0]       data,
  output logic [7:0]       fold
);
  import ilc_pkg::*;

  localparam logic [POS_W-1:0] MAC_FIRST = POS_W'(OFS);
  localparam logic [POS_W-1:0] MAC_LAST  = POS_W'(OFS + 11);

  logic [7:0] fold_q;
  logic       in_mac;

  assign in_mac = (idx >= MAC_FIRST) && (idx <= MAC_LAST);
  assign fold   = fold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fold_q <= '0;
    else if (take)
      fold_q <= fold_step(in_sof ? 8'h00 : fold_q, in_mac ? data : 8'h00);
  end

endmodule

// File: rtl/ilc_label_fsm.sv
module ilc_label_fsm #(
  parameter int OFS   = 4,
  parameter int POS_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take,
  input  logic [POS_W-1:0]         idx,
  input  logic [7:0]               data,
  input  logic                     in_eof,
  input  logic                     vlan_only,
  input  logic [7:0]               fold,
  output logic                     stop,
  output logic                     res_valid,
  output ilc_pkg::lbl_type_e       res_type,
  output logic [ilc_pkg::LBL_W-1:0] res_label,
  output logic [2:0]               res_prio,
  output logic                     res_dei,
  output logic                     res_drop,
  output logic                     res_trunc,
  output logic [ilc_pkg::KEY_W-1:0] res_flow_key
);
  import ilc_pkg::*;

  localparam logic [POS_W-1:0] P_ET1 = POS_W'(OFS + 13);
  localparam logic [POS_W-1:0] P_HI  = POS_W'(OFS + 15);
  localparam logic [POS_W-1:0] P_ET2 = POS_W'(OFS + 17);
  localparam logic [POS_W-1:0] P_LO  = POS_W'(OFS + 19);

  logic [7:0]  prev_q;
  logic        is_fine_q, is_fine_n;
  logic [15:0] hiw_q, hiw_n;
  logic [15:0] word;

  // decision outcome of the current byte, visible for checks
  logic             emit;
  logic             trunc;
  lbl_type_e        e_type;
  logic [LBL_W-1:0] e_label;
  logic [2:0]       e_prio;
  logic             e_dei;
  logic             e_drop;

  assign word = {prev_q, data};

  always_comb begin
    emit      = 1'b0;
    e_type    = LT_UNKNOWN;
    e_label   = '0;
    e_prio    = '0;
    e_dei     = 1'b0;
    e_drop    = 1'b1;
    is_fine_n = is_fine_q;
    hiw_n     = hiw_q;
    if (take) begin
      if (idx == P_ET1) begin
        if (word == ET_VLAN_TAG) begin
          is_fine_n = 1'b0;
        end else if (word == ET_FINE_TAG) begin
          is_fine_n = 1'b1;
          if (vlan_only) begin
            emit   = 1'b1;
            e_type = LT_REJECT;
          end
        end else begin
          emit = 1'b1;
        end
      end else if (idx == P_HI) begin
        if (!is_fine_q) begin
          emit    = 1'b1;
          e_type  = LT_VLAN;
          e_label = {12'h000, word[11:0]};
          e_prio  = word[15:13];
          e_dei   = word[12];
          e_drop  = 1'b0;
        end else begin
          hiw_n = word;
        end
      end else if (idx == P_ET2) begin
        if (word != ET_FINE_TAG)
          emit = 1'b1;
      end else if (idx == P_LO) begin
        emit    = 1'b1;
        e_type  = LT_FINE;
        e_label = fine_label(hiw_q, word);
        e_prio  = hiw_q[15:13];
        e_dei   = hiw_q[12];
        e_drop  = 1'b0;
      end
    end
  end

  assign stop  = emit;
  assign trunc = take && in_eof && !emit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      is_fine_q <= 1'b0;
      hiw_q     <= '0;
    end else if (take) begin
      prev_q    <= data;
      is_fine_q <= is_fine_n;
      hiw_q     <= hiw_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_trunc    <= 1'b0;
      res_type     <= LT_REJECT;
      res_label    <= '0;
      res_prio     <= '0;
      res_dei      <= 1'b0;
      res_drop     <= 1'b0;
      res_flow_key <= '0;
    end else begin
      res_valid <= emit;
      res_trunc <= trunc;
      if (emit) begin
        res_type     <= e_type;
        res_label    <= e_label;
        res_prio     <= e_prio;
        res_dei      <= e_dei;
        res_drop     <= e_drop;
        res_flow_key <= e_drop ? '0 : make_flow_key(e_label, fold);
      end
    end
  end

  // R8
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R6
  trunc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_trunc));

  // R3
  unknown_no_label_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_type == LT_UNKNOWN) |-> (res_label == '0 && res_drop));

  // R5
  reject_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_type == LT_REJECT) |-> (res_drop && res_label == '0));

  // R2
  fine_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_type == LT_FINE) |-> !res_drop);

  // R1
  vlan_label_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_type == LT_VLAN) |-> res_label[23:12] == 12'h000);

  // R7
  key_carries_label_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_drop) |-> res_flow_key[31:8] == res_label);

endmodule

// File: rtl/inner_label_classifier.sv
module inner_label_classifier #(
  parameter int INNER_OFS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic        vlan_only,
  output logic        res_valid,
  output logic [1:0]  res_type,
  output logic [23:0] res_label,
  output logic [2:0]  res_prio,
  output logic        res_dei,
  output logic        res_drop,
  output logic        res_trunc,
  output logic [31:0] res_flow_key
);
  import ilc_pkg::*;

  localparam int LIMIT = INNER_OFS + 20;
  localparam int POS_W = $clog2(LIMIT + 1);

  logic             take;
  logic             stop;
  logic [POS_W-1:0] idx;
  logic [7:0]       fold;
  lbl_type_e        type_e;

  ilc_pos_tracker #(.LIMIT(LIMIT), .POS_W(POS_W)) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .in_eof   (in_eof),
    .stop     (stop),
    .take     (take),
    .idx      (idx)
  );

  ilc_mac_fold #(.OFS(INNER_OFS), .POS_W(POS_W)) u_fold (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take),
    .in_sof (in_sof),
    .idx    (idx),
    .data   (in_data),
    .fold   (fold)
  );

  ilc_label_fsm #(.OFS(INNER_OFS), .POS_W(POS_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take),
    .idx          (idx),
    .data         (in_data),
    .in_eof       (in_eof),
    .vlan_only    (vlan_only),
    .fold         (fold),
    .stop         (stop),
    .res_valid    (res_valid),
    .res_type     (type_e),
    .res_label    (res_label),
    .res_prio     (res_prio),
    .res_dei      (res_dei),
    .res_drop     (res_drop),
    .res_trunc    (res_trunc),
    .res_flow_key (res_flow_key)
  );

  assign res_type = type_e;

endmodule

// File: tb/tb_inner_label_classifier.sv
`timescale 1ns/1ps
module tb_inner_label_classifier;
  localparam int OFS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic        vlan_only = 1'b0;
  logic        res_valid;
  logic [1:0]  res_type;
  logic [23:0] res_label;
  logic [2:0]  res_prio;
  logic        res_dei;
  logic        res_drop;
  logic        res_trunc;
  logic [31:0] res_flow_key;

  inner_label_classifier #(.INNER_OFS(OFS)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .vlan_only(vlan_only),
    .res_valid(res_valid), .res_type(res_type), .res_label(res_label),
    .res_prio(res_prio), .res_dei(res_dei), .res_drop(res_drop),
    .res_trunc(res_trunc), .res_flow_key(res_flow_key)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // captured results
  int          nval, ntr, val_cyc, tr_cyc, mark_cyc;
  logic [1:0]  c_type;
  logic [23:0] c_label;
  logic [2:0]  c_prio;
  logic        c_dei, c_drop;
  logic [31:0] c_key;

  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid) begin
        nval++; val_cyc = cyc;
        c_type = res_type; c_label = res_label; c_prio = res_prio;
        c_dei = res_dei; c_drop = res_drop; c_key = res_flow_key;
      end
      if (res_trunc) begin ntr++; tr_cyc = cyc; end
    end
  end

  logic [7:0] fb [0:39];
  int flen;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mac_xor();
    logic [7:0] x = 8'h00;
    for (int i = 0; i < 12; i++) x = x ^ fb[OFS + i];
    return x;
  endfunction

  task automatic base(input int seed, input logic [15:0] et);
    for (int i = 0; i < 40; i++) fb[i] = 8'h5A;
    for (int i = 0; i < OFS; i++) fb[i] = 8'hA0 + 8'(i);
    for (int i = 0; i < 12; i++) fb[OFS + i] = 8'(seed + i * 37);
    fb[OFS + 12] = et[15:8];
    fb[OFS + 13] = et[7:0];
  endtask

  task automatic put_word(input int at, input logic [15:0] w);
    fb[at] = w[15:8]; fb[at + 1] = w[7:0];
  endtask

  task automatic send(input int len, input int mark, input bit gaps);
    nval = 0; ntr = 0; val_cyc = -1; tr_cyc = -1; mark_cyc = -100;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fb[i];
      in_sof = (i == 0); in_eof = (i == len - 1);
      if (i == mark) mark_cyc = cyc;
      if (gaps) begin
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h89;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_result(input string req, input logic [1:0] ty,
                               input logic [23:0] lbl, input logic [2:0] pr,
                               input logic de, input logic dr, input bit keyed);
    logic [31:0] k;
    k = keyed ? {lbl, mac_xor()} : 32'h0;
    chk(nval == 1, req, "result count", nval, 1);
    chk(val_cyc == mark_cyc + 1, req, "result cycle", val_cyc, mark_cyc + 1);
    chk(c_type == ty, req, "type", c_type, ty);
    chk(c_label == lbl, req, "label", c_label, lbl);
    chk(c_prio == pr && c_dei == de, req, "prio/dei", {c_prio, c_dei}, {pr, de});
    chk(c_drop == dr, req, "drop", c_drop, dr);
    chk(c_key == k, req, "flow key", c_key, k);
    chk(ntr == 0, req, "no trunc", ntr, 0);
  endtask

  task automatic t_reset();
    chk(res_valid == 0 && res_trunc == 0, "R9", "strobes", {res_valid, res_trunc}, 0);
    chk(res_type == 0 && res_label == 0, "R9", "type/label", {res_type, res_label}, 0);
    chk(res_prio == 0 && !res_dei && !res_drop, "R9", "prio/dei/drop",
        {res_prio, res_dei, res_drop}, 0);
    chk(res_flow_key == 0, "R9", "key", res_flow_key, 0);
  endtask

  task automatic t_vlan();
    vlan_only = 1'b0;
    base(3, 16'h8100); put_word(OFS + 14, 16'hB5A7);
    send(OFS + 30, OFS + 15, 1'b0);
    expect_result("R1", 2'd1, 24'h0005A7, 3'd5, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_vlan_mode_gaps();
    vlan_only = 1'b1;
    base(77, 16'h8100); put_word(OFS + 14, 16'h2FFF);
    send(OFS + 20, OFS + 15, 1'b1);
    expect_result("R10", 2'd1, 24'h000FFF, 3'd1, 1'b0, 1'b0, 1'b1);
    vlan_only = 1'b0;
  endtask

  task automatic t_fine(input int seed, input logic [15:0] hi, input logic [15:0] lo,
                        output logic [31:0] key);
    base(seed, 16'h893B); put_word(OFS + 14, hi);
    put_word(OFS + 16, 16'h893B); put_word(OFS + 18, lo);
    send(OFS + 26, OFS + 19, 1'b0);
    expect_result("R2", 2'd2, {hi[11:0], lo[11:0]}, hi[15:13], hi[12], 1'b0, 1'b1);
    key = c_key;
  endtask

  task automatic t_fine_keys();
    logic [31:0] k1, k2, k3;
    t_fine(9, 16'h6ABC, 16'h9123, k1);
    t_fine(9, 16'h6ABC, 16'h9124, k2);
    t_fine(9, 16'h7ABD, 16'h9123, k3);
    chk(k1 != k2 && k1 != k3, "R7", "keys distinct by either part", k1, k2);
  endtask

  task automatic t_unknown();
    base(21, 16'h0800);
    put_word(OFS + 14, 16'h8100); put_word(OFS + 16, 16'h893B);
    send(OFS + 28, OFS + 13, 1'b0);
    expect_result("R3", 2'd3, 24'h0, 3'd0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_bad_second();
    base(40, 16'h893B); put_word(OFS + 14, 16'hE123);
    put_word(OFS + 16, 16'h8100); put_word(OFS + 18, 16'h4456);
    send(OFS + 24, OFS + 17, 1'b0);
    expect_result("R4", 2'd3, 24'h0, 3'd0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_reject();
    vlan_only = 1'b1;
    base(55, 16'h893B); put_word(OFS + 14, 16'hE123);
    put_word(OFS + 16, 16'h893B); put_word(OFS + 18, 16'h4456);
    send(OFS + 24, OFS + 13, 1'b0);
    expect_result("R5", 2'd0, 24'h0, 3'd0, 1'b0, 1'b1, 1'b0);
    vlan_only = 1'b0;
  endtask

  task automatic t_trunc();
    base(12, 16'h893B); put_word(OFS + 14, 16'h1111);
    put_word(OFS + 16, 16'h893B);
    send(OFS + 18, OFS + 17, 1'b0);
    chk(ntr == 1, "R6", "trunc count fine", ntr, 1);
    chk(tr_cyc == mark_cyc + 1, "R6", "trunc cycle", tr_cyc, mark_cyc + 1);
    chk(nval == 0, "R6", "no result fine", nval, 0);
    base(13, 16'h8100);
    send(OFS + 15, OFS + 14, 1'b1);
    chk(ntr == 1 && nval == 0, "R6", "trunc vlan", {ntr, nval}, {32'd1, 32'd0});
    base(14, 16'h8100); put_word(OFS + 14, 16'h0123);
    send(OFS + 16, OFS + 15, 1'b0);
    expect_result("R6", 2'd1, 24'h000123, 3'd0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_outside();
    nval = 0; ntr = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_eof = (i == 29);
      in_data = (i % 2 == 0) ? 8'h81 : 8'h00;
    end
    @(negedge clk); in_valid = 1'b0; in_eof = 1'b0;
    repeat (3) @(negedge clk);
    chk(nval == 0 && ntr == 0, "R8", "bytes outside frame ignored", {nval, ntr}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_vlan();
    t_vlan_mode_gaps();
    t_fine_keys();
    t_unknown();
    t_bad_second();
    t_reject();
    t_trunc();
    t_outside();
    t_vlan();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule